// File: doc/BRIEF.md
# Slew-Limited Reference Code Sequencer

This block produces the 7-bit reference code that drives the output DAC of a programmable step-down regulator. The output level is 0.35 V plus the code times 6.25 mV, so codes 0 to 127 span 0.35 V to 1.14375 V. Two setpoint codes are presented to the block. A select pin picks which of them is the live target.

When the target moves up, the code climbs one LSB at a time. The pace is set by a 3-bit slew field: each higher field value doubles the number of clock cycles per step. When the target moves down, the code jumps straight to the new value. The block then holds a switching-inhibit line high until an external comparator reports that the output has discharged to the new level.

Enabling the block starts a soft-start. The code begins at zero and climbs at a fixed slow rate. A done flag rises once the target is met. Separate flags report upward and downward transitions in progress.

Top module: `vref_sequencer`

## Requirements
- R1: The DAC code output never leaves 0..127 and never wraps. Once it equals the target it holds that value while the target is unchanged.
- R2: With the select pin low the target is setpoint 0. With it high the target is setpoint 1. A target change takes effect two clock edges after it is applied.
- R3: During an upward ramp, consecutive code steps are exactly BASE_TICK << slew clock cycles apart, where slew is the 3-bit field value (0 is the fastest, 7 the slowest).
- R4: During an upward ramp the code rises by exactly +1 per step, never skips or falls, and stops at the target. The rising flag is 1 throughout and returns to 0 after the target is reached.
- R5: When the target drops below the code, the code takes the target value in one edge. Switch-inhibit and the falling flag then stay 1 until the reached input is sampled high, and return to 0 on that edge.
- R6: On enable, the code starts at 0 and ramps toward the target at slew value SS_SLEW (6 by default), with the rising flag set.
- R7: The soft-start-done flag becomes 1 when the soft-start code meets or passes the target. It stays 1 until enable goes low.
- R8: If the target is raised mid-ramp, the ramp continues from the current code at the same pace. If it is lowered below the current code, the falling behaviour of R5 applies.
- R9: With enable low, the next edge forces the code to 0 and clears the rising, falling, inhibit and done flags.
- R10: After a synchronous reset the code is 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable; starts soft-start when raised |
| sel | input | 1 | Chooses setpoint 0 (low) or setpoint 1 (high) |
| setpt0 | input | 7 | Setpoint code 0 |
| setpt1 | input | 7 | Setpoint code 1 |
| slew | input | 3 | Upward ramp rate field |
| at_target | input | 1 | Comparator: output has fallen to the setpoint |
| code_out | output | 7 | Reference code to the DAC |
| sw_inhibit | output | 1 | Stop switching during a downward transition |
| rising_flag | output | 1 | Upward transition or soft-start in progress |
| falling_flag | output | 1 | Downward transition in progress |
| ss_done | output | 1 | Soft-start completed |

## Verification
The step-counter bound check assumes the slew field does not change while a ramp is running. The stimulus therefore writes the slew field only while the code is settled or the block is disabled. The comparator input is taken to be meaningful only during a downward transition. The bench raises it only after checking that the inhibit line held through a wait, and drops it before the next transition. The one-step-per-edge and flag-exclusion properties rely on enable being sampled synchronously, which the bench keeps by driving every input on the falling clock edge.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    SEQ_OFF  = 3'd0,
    SEQ_SOFT = 3'd1,
    SEQ_IDLE = 3'd2,
    SEQ_RISE = 3'd3,
    SEQ_FALL = 3'd4
  } seq_state_t;
endpackage

// File: rtl/vseq_target_sel.sv
module vseq_target_sel #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [CODE_W-1:0] setpt0,
  input  logic [CODE_W-1:0] setpt1,
  output logic [CODE_W-1:0] target
);
  always_ff @(posedge clk) begin
    if (rst) target <= '0;
    else     target <= sel ? setpt1 : setpt0;
  end
endmodule

// File: rtl/vseq_tick_gen.sv
module vseq_tick_gen #(
  parameter int BASE_TICK = 16,
  parameter int SLEW_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [SLEW_W-1:0] rate,
  output logic              tick
);
  localparam int MAX_PER = BASE_TICK << ((1 << SLEW_W) - 1);
  localparam int CNT_W   = $clog2(MAX_PER + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(BASE_TICK) << rate;
  assign tick   = run && (cnt_q >= period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3: step counter stays inside the selected period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < period));
endmodule

// File: rtl/vseq_ramp_fsm.sv
module vseq_ramp_fsm
  import vseq_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] target,
  input  logic              tick,
  input  logic              at_target,
  output logic [CODE_W-1:0] code_q,
  output logic              run,
  output logic              in_soft,
  output logic              rise_q,
  output logic              fall_q,
  output logic              inh_q,
  output logic              done_q
);
  seq_state_t state_q;

  assign run     = (state_q == SEQ_SOFT) || (state_q == SEQ_RISE);
  assign in_soft = (state_q == SEQ_SOFT);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q <= SEQ_OFF;
      code_q  <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      inh_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_OFF: begin
          state_q <= SEQ_SOFT;
          code_q  <= '0;
          rise_q  <= 1'b1;
        end
        SEQ_SOFT, SEQ_RISE: begin
          if (code_q == target) begin
            state_q <= SEQ_IDLE;
            rise_q  <= 1'b0;
            done_q  <= 1'b1;
          end else if (code_q > target) begin
            state_q <= SEQ_FALL;
            code_q  <= target;
            rise_q  <= 1'b0;
            fall_q  <= 1'b1;
            inh_q   <= 1'b1;
            done_q  <= 1'b1;
          end else if (tick) begin
            code_q <= code_q + CODE_W'(1);
          end
        end
        SEQ_IDLE: begin
          if (target > code_q) begin
            state_q <= SEQ_RISE;
            rise_q  <= 1'b1;
          end else if (target < code_q) begin
            state_q <= SEQ_FALL;
            code_q  <= target;
            fall_q  <= 1'b1;
            inh_q   <= 1'b1;
          end
        end
        SEQ_FALL: begin
          if (target < code_q) begin
            code_q <= target;
          end else if (at_target) begin
            state_q <= SEQ_IDLE;
            fall_q  <= 1'b0;
            inh_q   <= 1'b0;
          end
        end
        default: state_q <= SEQ_OFF;
      endcase
    end
  end

  // R4: while rising, the code only ever advances by one LSB
  assert_rise_step_R4: assert property (@(posedge clk) disable iff (rst)
    (rise_q && $past(rise_q) && (code_q != $past(code_q)))
      |-> (code_q == $past(code_q) + CODE_W'(1)));

  // R5: rising and falling transitions never overlap
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_q, fall_q}));

  // R9: enable low clears code and transition flags on the next edge
  assert_off_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (code_q == '0 && !rise_q && !fall_q && !inh_q && !done_q));

  // R7: done flag is sticky while enabled
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && en) |=> done_q);
endmodule

// File: rtl/vref_sequencer.sv
module vref_sequencer #(
  parameter int CODE_W    = 7,
  parameter int SLEW_W    = 3,
  parameter int BASE_TICK = 16,
  parameter int SS_SLEW   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel,
  input  logic [CODE_W-1:0] setpt0,
  input  logic [CODE_W-1:0] setpt1,
  input  logic [SLEW_W-1:0] slew,
  input  logic              at_target,
  output logic [CODE_W-1:0] code_out,
  output logic              sw_inhibit,
  output logic              rising_flag,
  output logic              falling_flag,
  output logic              ss_done
);
  logic [CODE_W-1:0] target;
  logic [SLEW_W-1:0] rate;
  logic              tick;
  logic              run;
  logic              in_soft;

  vseq_target_sel #(.CODE_W(CODE_W)) u_tsel (
    .clk(clk), .rst(rst), .sel(sel),
    .setpt0(setpt0), .setpt1(setpt1), .target(target)
  );

  assign rate = in_soft ? SLEW_W'(SS_SLEW) : slew;

  vseq_tick_gen #(.BASE_TICK(BASE_TICK), .SLEW_W(SLEW_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .rate(rate), .tick(tick)
  );

  vseq_ramp_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .target(target), .tick(tick),
    .at_target(at_target), .code_q(code_out), .run(run), .in_soft(in_soft),
    .rise_q(rising_flag), .fall_q(falling_flag), .inh_q(sw_inhibit),
    .done_q(ss_done)
  );
endmodule

// File: tb/vref_sequencer_tb.sv
module vref_sequencer_tb_top;
  localparam int BASE = 2;
  localparam int SSR  = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, sel = 1'b0, at_target = 1'b0;
  logic [6:0] setpt0 = '0, setpt1 = '0;
  logic [2:0] slew = '0;
  logic [6:0] code_out;
  logic       sw_inhibit, rising_flag, falling_flag, ss_done;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vref_sequencer #(.BASE_TICK(BASE), .SS_SLEW(SSR)) dut_i (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .setpt0(setpt0), .setpt1(setpt1),
    .slew(slew), .at_target(at_target), .code_out(code_out),
    .sw_inhibit(sw_inhibit), .rising_flag(rising_flag),
    .falling_flag(falling_flag), .ss_done(ss_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Follows an upward ramp to exp_tgt; checks +1 steps, spacing and flag.
  task automatic ramp_watch(input int exp_tgt, input int exp_per, input string tag);
    int prev, cnt, steps, bad_step, bad_per, bad_flag, guard;
    cyc(2);
    prev = code_out; cnt = 0; steps = 0;
    bad_step = -1; bad_per = -1; bad_flag = 0; guard = 0;
    while (code_out != exp_tgt && guard < 60000) begin
      @(negedge clk);
      cnt++; guard++;
      if (!rising_flag) bad_flag++;
      if (code_out != prev) begin
        if (code_out != prev + 1) bad_step = code_out;
        if (steps > 0 && cnt != exp_per) bad_per = cnt;
        steps++; cnt = 0; prev = code_out;
      end
    end
    check(bad_step < 0, {tag, " R4 step +1"}, bad_step, prev + 1);
    check(bad_per < 0, {tag, " R3 spacing"}, bad_per, exp_per);
    check(bad_flag == 0, {tag, " R4 rising flag held"}, bad_flag, 0);
    check(code_out == exp_tgt, {tag, " R1 final code"}, code_out, exp_tgt);
    cyc(2);
    check(rising_flag == 1'b0, {tag, " R4 rising flag clears"}, rising_flag, 0);
  endtask

  initial begin
    cyc(5);
    // R10: reset state
    check(code_out == 0 && !sw_inhibit && !rising_flag && !falling_flag && !ss_done,
          "R10 reset state", {code_out, sw_inhibit, rising_flag, falling_flag, ss_done}, 0);
    rst = 1'b0;
    cyc(2);

    // R6 / R7: soft-start from zero at the fixed slow rate, sel low (R2)
    setpt0 = 7'd10; setpt1 = 7'd8; sel = 1'b0;
    en = 1'b1;
    @(negedge clk);
    check(code_out == 0 && rising_flag, "R6 soft-start begins at 0", code_out, 0);
    ramp_watch(10, BASE << SSR, "R6 soft-start");
    check(ss_done == 1'b1, "R7 soft-start done", ss_done, 1);
    check(code_out == 10, "R2 setpoint 0 selected", code_out, 10);

    // R5 / R2: select setpoint 1 (lower) -> jump and inhibit
    sel = 1'b1;
    cyc(3);
    check(code_out == 8, "R5 falling jump / R2 setpoint 1", code_out, 8);
    check(sw_inhibit && falling_flag, "R5 inhibit asserted", {sw_inhibit, falling_flag}, 3);
    cyc(12);
    check(sw_inhibit && falling_flag && code_out == 8, "R5 inhibit held until reached",
          {sw_inhibit, falling_flag}, 3);
    at_target = 1'b1;
    @(negedge clk);
    at_target = 1'b0;
    check(!sw_inhibit && !falling_flag, "R5 release on reached", {sw_inhibit, falling_flag}, 0);
    check(ss_done == 1'b1, "R7 done stays high", ss_done, 1);

    // R3: sweep all eight slew codes
    for (int s = 0; s < 8; s++) begin
      slew = 3'(s);
      setpt1 = 7'(8 + 4 * (s + 1));
      ramp_watch(8 + 4 * (s + 1), BASE << s, $sformatf("R3 slew %0d", s));
    end

    // R8: raise target mid-ramp
    slew = 3'd0;
    setpt1 = 7'd60;
    cyc(2);
    while (code_out < 50) @(negedge clk);
    setpt1 = 7'd70;
    ramp_watch(70, BASE, "R8 retarget up");

    // R8: lower target below current code mid-ramp
    setpt1 = 7'd90;
    cyc(2);
    while (code_out < 80) @(negedge clk);
    setpt1 = 7'd75;
    cyc(3);
    check(code_out == 75 && falling_flag && sw_inhibit && !rising_flag,
          "R8 retarget down -> falling", code_out, 75);
    at_target = 1'b1;
    @(negedge clk);
    at_target = 1'b0;
    check(!falling_flag && !sw_inhibit, "R8 falling clears", falling_flag, 0);

    // R1: top of range, no wrap
    setpt1 = 7'd127;
    ramp_watch(127, BASE, "R1 top");
    cyc(40);
    check(code_out == 127 && !rising_flag, "R1 holds at 127", code_out, 127);

    // R9: disable clears everything
    en = 1'b0;
    @(negedge clk);
    check(code_out == 0 && !rising_flag && !falling_flag && !sw_inhibit && !ss_done,
          "R9 disable clears", code_out, 0);

    // R7: soft-start toward a zero target completes at once
    sel = 1'b0; setpt0 = 7'd0;
    cyc(3);
    en = 1'b1;
    cyc(4);
    check(ss_done && !rising_flag && code_out == 0, "R7 zero-target soft-start",
          {ss_done, rising_flag}, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule